// File: doc/BRIEF.md
# Bus-Cycle Ready Synchronizer

This block produces the one active-low ready strobe that closes a processor local-bus operation. Both the bus master and the bus controller see this strobe, so it is a single registered output that follows the system clock. The block also tracks the bus state itself. An operation is one status state (Ts) followed by one or more command states (Tc). With no request the bus is idle (Ti). A one-clock strobe on `cycle_start_i` requests the next operation.

The block runs from a double-rate clock. An internal phase toggle splits each system clock into phase 1 and phase 2, and state moves only at the end of phase 2. Two ready sources can end a Tc, and each has its own active-low enable driven by address decode. The synchronous ready already meets setup and hold, so it is sampled directly at the end of phase 1 and can end the very first Tc. The asynchronous ready is captured at every system-clock boundary into a chain of `SYNC_STAGES` flops, which gives it a full system clock to settle. It is never honoured in the first Tc, so an asynchronous ready always costs at least one wait state.

Top module: `bus_ready_sync`

## Requirements
- R1: While reset is asserted and right after it, `ready_no` is 1, `bus_state_o` is Ti (2'b00) and `phase_o` is 0 (phase 1).
- R2: `phase_o` alternates on every `clk_i` edge (0 = phase 1, 1 = phase 2). `bus_state_o` changes only on the edge that ends phase 2, so it holds its value across each system clock.
- R3: A pending request moves Ti (2'b00) to Ts (2'b01) at the next system-clock boundary. Ts always lasts exactly one system clock and is followed by Tc (2'b10).
- R4: Tc repeats until ready is given. After the final Tc, the bus goes to Ts if another `cycle_start_i` strobe arrived meanwhile, and to Ti otherwise.
- R5: `srdy_ni` and `srdy_en_ni` are sampled together at the end of phase 1 of each Tc. If both are low, that Tc is the last one, which allows a zero-wait operation (a single Tc).
- R6: A low level on `srdy_ni` that is present only outside phase 1 of a Tc has no effect.
- R7: `ardy_ni` and `ardy_en_ni` are sampled together at every system-clock boundary. If both are low at the boundary that starts Tc number k, ready follows in Tc number k+SYNC_STAGES-1.
- R8: The asynchronous source never ends the first Tc. When it is asserted during Ts, or held low before the operation starts, the operation has exactly two Tc states with the default chain.
- R9: A source whose enable is high is ignored, even if its ready input is low. The bus stays in Tc until an enabled source asserts.
- R10: `ready_no` goes low only during phase 2 of a Tc, and for exactly one `clk_i` cycle per operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Double-rate clock; two edges per system clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cycle_start_i | input | 1 | One-clock strobe requesting a new bus operation |
| srdy_ni | input | 1 | Synchronous ready, active low |
| srdy_en_ni | input | 1 | Enable for the synchronous ready, active low |
| ardy_ni | input | 1 | Asynchronous ready, active low |
| ardy_en_ni | input | 1 | Enable for the asynchronous ready, active low |
| ready_no | output | 1 | Cycle-end strobe to bus master and controller, active low |
| bus_state_o | output | 2 | Bus state: 00 Ti, 01 Ts, 10 Tc |
| phase_o | output | 1 | 0 in phase 1, 1 in phase 2 |

## Verification
The bench builds the block with the default `SYNC_STAGES` of 2. With that setting every asynchronous latency is an exact count: ready in the second Tc when asserted during Ts, the third when asserted in Tc 1, and the fourth when asserted in Tc 2. Each operation's length can therefore be predicted to the Tc. The two-stage chain also puts the first-Tc exclusion within reach, because an asynchronous ready held low before the request would otherwise reach the output in time to end Tc 1.

// File: rtl/brs_pkg.sv
package brs_pkg;
  typedef enum logic [1:0] {
    BS_TI = 2'b00,
    BS_TS = 2'b01,
    BS_TC = 2'b10
  } bus_state_e;
endpackage

// File: rtl/brs_phase_gen.sv
module brs_phase_gen (
  input  logic clk_i,
  input  logic rst_ni,
  output logic phase_o,
  output logic bound_o,
  output logic mid_o
);
  logic phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= 1'b0;
    else         phase_q <= ~phase_q;
  end

  assign phase_o = phase_q;
  assign bound_o = phase_q;   // edge ending phase 2 = system clock boundary
  assign mid_o   = ~phase_q;  // edge ending phase 1
endmodule

// File: rtl/brs_state_tracker.sv
module brs_state_tracker
  import brs_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bound_i,
  input  logic       start_i,
  input  logic       rdy_i,
  output bus_state_e state_o,
  output logic       first_tc_o
);
  bus_state_e state_q, state_d;
  logic       pend_q, first_q, take;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      BS_TI:   if (pend_q) state_d = BS_TS;
      BS_TS:   state_d = BS_TC;
      BS_TC:   if (rdy_i) state_d = pend_q ? BS_TS : BS_TI;
      default: state_d = BS_TI;
    endcase
  end

  assign take = bound_i && (state_d == BS_TS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= BS_TI;
      pend_q  <= 1'b0;
      first_q <= 1'b0;
    end else begin
      pend_q <= start_i | (pend_q & ~take);
      if (bound_i) begin
        state_q <= state_d;
        first_q <= (state_q == BS_TS);
      end
    end
  end

  assign state_o    = state_q;
  assign first_tc_o = first_q;

  AST_STATE_AT_BOUND_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bound_i |=> $stable(state_q)); // R2
  AST_TS_ONE_CLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bound_i && state_q == BS_TS |=> state_q == BS_TC); // R3
  AST_TC_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bound_i && state_q == BS_TC && !rdy_i |=> state_q == BS_TC); // R4
  AST_IDLE_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bound_i && state_q == BS_TC && rdy_i && !pend_q |=> state_q == BS_TI); // R4
endmodule

// File: rtl/brs_async_sync.sv
module brs_async_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bound_i,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      chain_q[g] <= 1'b0;
      else if (bound_i) chain_q[g] <= (g == 0) ? d_i : chain_q[(g == 0) ? 0 : g-1];
    end
  end

  assign q_o = chain_q[STAGES-1];

  AST_SYNC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bound_i |=> $stable(q_o)); // R7
endmodule

// File: rtl/brs_ready_merge.sv
module brs_ready_merge
  import brs_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       mid_i,
  input  logic       bound_i,
  input  bus_state_e state_i,
  input  logic       first_tc_i,
  input  logic       srdy_ni,
  input  logic       srdy_en_ni,
  input  logic       async_i,
  output logic       ready_no
);
  logic ready_q, srdy_hit, async_hit;

  assign srdy_hit  = ~srdy_ni & ~srdy_en_ni;
  assign async_hit = async_i & ~first_tc_i;  // no zero-wait via async path

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          ready_q <= 1'b1;
    else if (bound_i)                     ready_q <= 1'b1;
    else if (mid_i && state_i == BS_TC)   ready_q <= ~(srdy_hit | async_hit);
  end

  assign ready_no = ready_q;

  AST_READY_IN_TC_PH2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_q |-> state_i == BS_TC && bound_i); // R10
  AST_READY_ONE_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_q |=> ready_q); // R10
  AST_FIRST_TC_SYNC_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ready_q) && first_tc_i |-> $past(!srdy_ni && !srdy_en_ni)); // R8
  AST_ENABLED_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ready_q) |-> $past(!srdy_en_ni) || $past(async_i)); // R9
endmodule

// File: rtl/bus_ready_sync.sv
module bus_ready_sync
  import brs_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cycle_start_i,
  input  logic       srdy_ni,
  input  logic       srdy_en_ni,
  input  logic       ardy_ni,
  input  logic       ardy_en_ni,
  output logic       ready_no,
  output logic [1:0] bus_state_o,
  output logic       phase_o
);
  logic       bound, mid, first_tc, async_q, ardy_hit;
  bus_state_e state;

  assign ardy_hit = ~ardy_ni & ~ardy_en_ni;  // enable rides with its ready

  brs_phase_gen i_phase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .phase_o (phase_o),
    .bound_o (bound),
    .mid_o   (mid)
  );

  brs_state_tracker i_track (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bound_i    (bound),
    .start_i    (cycle_start_i),
    .rdy_i      (~ready_no),
    .state_o    (state),
    .first_tc_o (first_tc)
  );

  brs_async_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .bound_i (bound),
    .d_i     (ardy_hit),
    .q_o     (async_q)
  );

  brs_ready_merge i_merge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mid_i      (mid),
    .bound_i    (bound),
    .state_i    (state),
    .first_tc_i (first_tc),
    .srdy_ni    (srdy_ni),
    .srdy_en_ni (srdy_en_ni),
    .async_i    (async_q),
    .ready_no   (ready_no)
  );

  assign bus_state_o = state;
endmodule

// File: tb/test_bus_ready_sync.sv
module test_bus_ready_sync;
  localparam logic [1:0] ST_TI = 2'b00, ST_TS = 2'b01, ST_TC = 2'b10;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic cycle_start_i = 1'b0;
  logic srdy_ni = 1'b1, srdy_en_ni = 1'b1, ardy_ni = 1'b1, ardy_en_ni = 1'b1;
  logic ready_no, phase_o;
  logic [1:0] bus_state_o;

  int n_chk = 0, n_fail = 0;

  always #10 clk_i = ~clk_i;

  bus_ready_sync i_bus_ready_sync (
    .clk_i, .rst_ni, .cycle_start_i, .srdy_ni, .srdy_en_ni,
    .ardy_ni, .ardy_en_ni, .ready_no, .bus_state_o, .phase_o
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle();
    srdy_ni = 1; srdy_en_ni = 1; ardy_ni = 1; ardy_en_ni = 1; cycle_start_i = 0;
    repeat (6) @(negedge clk_i);
  endtask

  // Runs one operation; returns Tc count, ready strobes, misplaced events, state after.
  task automatic run_op(input logic s_n, input logic s_en_n, input logic a_n, input logic a_en_n,
                        input int srdy_tc, input int ardy_tc, input bit ardy_ts,
                        input bit again, input int p2_tc,
                        output int tc_n, output int rdy_n, output int bad_n, output logic [1:0] after_st);
    int tc_idx = 0;
    bit seen = 0, p2_armed = 0;
    logic [1:0] prev;
    rdy_n = 0; bad_n = 0; after_st = 2'b11;
    @(negedge clk_i);
    srdy_ni = s_n; srdy_en_ni = s_en_n; ardy_ni = a_n; ardy_en_ni = a_en_n;
    cycle_start_i = 1;
    @(negedge clk_i);
    cycle_start_i = 0;
    prev = bus_state_o;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk_i);
      cycle_start_i = 0;
      if (p2_armed) begin srdy_ni = 1; p2_armed = 0; end
      if (phase_o && bus_state_o != prev) bad_n++;
      prev = bus_state_o;
      if (!ready_no) begin
        rdy_n++;
        if (!(bus_state_o == ST_TC && phase_o)) bad_n++;
      end
      if (bus_state_o == ST_TS && !phase_o && ardy_ts) begin ardy_ni = 0; ardy_en_ni = 0; end
      if (bus_state_o == ST_TC && !phase_o) begin
        tc_idx++; seen = 1;
        if (tc_idx == srdy_tc) begin srdy_ni = 0; srdy_en_ni = 0; end
        if (tc_idx == ardy_tc) begin ardy_ni = 0; ardy_en_ni = 0; end
        if (again && tc_idx == 1) cycle_start_i = 1;
      end
      if (bus_state_o == ST_TC && phase_o && tc_idx == p2_tc) begin srdy_ni = 0; p2_armed = 1; end
      if (seen && bus_state_o != ST_TC) begin after_st = bus_state_o; break; end
    end
    tc_n = tc_idx;
  endtask

  task automatic expect_op(input string req, input int tc_n, input int rdy_n, input int bad_n,
                           input logic [1:0] after_st, input int tc_exp, input logic [1:0] after_exp);
    chk(tc_n == tc_exp, req, "Tc count", tc_n, tc_exp);
    chk(rdy_n == 1, "R10", "ready strobes per op", rdy_n, 1);
    chk(bad_n == 0, "R10", "ready/state misplaced in phase", bad_n, 0);
    chk(after_st == after_exp, "R4", "state after last Tc", after_st, after_exp);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk_i);
    chk(ready_no == 1, "R1", "ready_no in reset", ready_no, 1);
    chk(bus_state_o == ST_TI, "R1", "state in reset", bus_state_o, ST_TI);
    chk(phase_o == 0, "R1", "phase in reset", phase_o, 0);
    rst_ni = 1;
    @(negedge clk_i);
    chk(phase_o == 1, "R2", "phase after 1 edge", phase_o, 1);
    @(negedge clk_i);
    chk(phase_o == 0, "R2", "phase after 2 edges", phase_o, 0);
    repeat (4) @(negedge clk_i);
    chk(bus_state_o == ST_TI && ready_no == 1, "R1", "idle with no request", bus_state_o, ST_TI);
  endtask

  task automatic t_sync_zero_wait();
    int t, r, b; logic [1:0] a;
    run_op(0, 0, 1, 1, 0, 0, 0, 0, 0, t, r, b, a);
    expect_op("R5", t, r, b, a, 1, ST_TI);
    idle();
  endtask

  task automatic t_sync_waits();
    int t, r, b; logic [1:0] a;
    run_op(1, 0, 1, 1, 3, 0, 0, 0, 0, t, r, b, a);
    expect_op("R5", t, r, b, a, 3, ST_TI);
    idle();
  endtask

  task automatic t_sync_phase2_ignored();
    int t, r, b; logic [1:0] a;
    run_op(1, 0, 1, 1, 3, 0, 0, 0, 1, t, r, b, a);
    expect_op("R6", t, r, b, a, 3, ST_TI);
    idle();
  endtask

  task automatic t_async_in_ts();
    int t, r, b; logic [1:0] a;
    run_op(1, 1, 1, 1, 0, 0, 1, 0, 0, t, r, b, a);
    expect_op("R8", t, r, b, a, 2, ST_TI);
    idle();
  endtask

  task automatic t_async_held();
    int t, r, b; logic [1:0] a;
    ardy_ni = 0; ardy_en_ni = 0;
    repeat (6) @(negedge clk_i);
    run_op(1, 1, 0, 0, 0, 0, 0, 0, 0, t, r, b, a);
    expect_op("R8", t, r, b, a, 2, ST_TI);
    idle();
  endtask

  task automatic t_async_latency();
    int t, r, b; logic [1:0] a;
    run_op(1, 1, 1, 1, 0, 1, 0, 0, 0, t, r, b, a);
    expect_op("R7", t, r, b, a, 3, ST_TI);
    idle();
    run_op(1, 1, 1, 1, 0, 2, 0, 0, 0, t, r, b, a);
    expect_op("R7", t, r, b, a, 4, ST_TI);
    idle();
  endtask

  task automatic t_disabled_sources();
    int t, r, b; logic [1:0] a;
    run_op(0, 1, 1, 1, 5, 0, 0, 0, 0, t, r, b, a);   // sync low but disabled
    expect_op("R9", t, r, b, a, 5, ST_TI);
    idle();
    run_op(1, 0, 0, 1, 4, 0, 0, 0, 0, t, r, b, a);   // async low but disabled
    expect_op("R9", t, r, b, a, 4, ST_TI);
    idle();
  endtask

  task automatic t_back_to_back();
    int t, r, b; logic [1:0] a;
    run_op(0, 0, 1, 1, 0, 0, 0, 1, 0, t, r, b, a);
    expect_op("R4", t, r, b, a, 1, ST_TS);
    repeat (10) @(negedge clk_i);
    chk(bus_state_o == ST_TI, "R4", "idle after second op", bus_state_o, ST_TI);
    chk(bus_state_o == ST_TI || !phase_o, "R3", "second op finished", bus_state_o, ST_TI);
    idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog R4: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_sync_zero_wait();
    t_sync_waits();
    t_sync_phase2_ignored();
    t_async_in_ts();
    t_async_held();
    t_async_latency();
    t_disabled_sources();
    t_back_to_back();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule